// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block sits between a simple request port and a four-bank single-data-rate SDRAM. It takes one request at a time: a linear word address, a direction flag and, for a write, one data word. Each request becomes a complete, timed command sequence. First the bank is opened with ACTIVE. Then, after the row-to-column delay, the transfer is issued as READ or WRITE. Then, after the read latency or the write recovery time, the bank is closed with PRECHARGE. The next request is not taken until the precharge recovery time has passed.

The linear address is split as {bank, row, column}, with the column in the least significant bits. The row is driven on the address pins with ACTIVE. The column is driven with READ or WRITE, and all address bits above the column field are held at zero. The default column field is 9 bits wide, for a 16-bit device. Setting the `WIDE_COL` parameter widens it to 10 bits, for a byte-wide device. Read data is sampled from the data bus a fixed number of edges after the READ command and is returned with a one-cycle strobe. The block accepts nothing until the memory's power-up initialization is reported as done.

Top module: `sdram_seq`

## Requirements
- R1: While `init_done` has not been seen high, `ready` stays low, requests are ignored, and the command pins carry only NOP or deselect ({ras_n,cas_n,we_n} = 3'b111).
- R2: The first cycle after a request is accepted carries ACTIVE ({ras_n,cas_n,we_n} = 3'b011, cs_n low). `sd_ba` carries address bits [ADDR_W-1:ADDR_W-2], and `sd_a[11:0]` carries the 12 row bits directly below them.
- R3: READ (3'b101) or WRITE (3'b100) appears exactly T_RCD cycles after the ACTIVE cycle, on the same bank. `sd_a[COL_W-1:0]` carries the low COL_W address bits (COL_W = 9, or 10 when WIDE_COL = 1), and the remaining address pins are zero.
- R4: PRECHARGE (3'b010) of the same bank, with `sd_a[10]` low, appears exactly CAS_LAT cycles after a READ cycle and exactly T_WR cycles after a WRITE cycle.
- R5: `ready` is low in the cycle after a request is accepted. It returns high exactly T_RP cycles after the PRECHARGE cycle, and no command other than NOP is driven while it is high.
- R6: During a read, `sd_dq_oe` stays low. `rd_data` takes the value on `sd_dq_in` at the clock edge CAS_LAT+1 edges after the start of the READ cycle, and `rd_valid` is high for exactly that one following cycle.
- R7: For a write, `sd_dq_oe` is high and `sd_dq_out` equals the request's data in the WRITE cycle only. `sd_dq_oe` is low in every other cycle.
- R8: `sd_dqm` is high while the sequencer is idle. It is low from the ACTIVE cycle until the cycle in which `ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Memory power-up sequence complete |
| req_valid | input | 1 | Request present; taken on an edge where `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Linear word address {bank,row,column} |
| req_wdata | input | DQ_W | Write data |
| ready | output | 1 | Sequencer can take a request |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DQ_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low (high in reset) |
| sd_ras_n | output | 1 | Row strobe command bit |
| sd_cas_n | output | 1 | Column strobe command bit |
| sd_we_n | output | 1 | Write enable command bit |
| sd_ba | output | BANK_W | Bank select |
| sd_a | output | A_W | Multiplexed row/column address |
| sd_dqm | output | 1 | Data mask, active high |
| sd_dq_out | output | DQ_W | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | DQ_W | Data returned by the memory |

## Verification
Several rules are checked on every cycle by assertions. No command is driven while the block is idle. The column command always sits T_RCD cycles after the open. The data driver is enabled only with WRITE. PRECHARGE targets the open bank with the all-banks bit low. The read strobe never lasts two cycles. Only the bench scenarios can show the rest: that the bank, row and column fields are cut from the right address bits; that read data returns at the correct edge and matches what was written; that PRECHARGE and the return of `ready` are placed exactly; and that requests made before initialization leave no trace.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_POST,
    ST_RP
  } seq_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int A_W    = 12,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] lin_addr,
  output logic [BANK_W-1:0] bank,
  output logic [A_W-1:0]    row_pins,
  output logic [A_W-1:0]    col_pins
);

  assign bank = lin_addr[ADDR_W-1 -: BANK_W];

  generate
    if (ROW_W < A_W) begin : g_row_pad
      assign row_pins = {{(A_W-ROW_W){1'b0}}, lin_addr[COL_W +: ROW_W]};
    end else begin : g_row_full
      assign row_pins = lin_addr[COL_W +: A_W];
    end

    if (COL_W < A_W) begin : g_col_pad
      assign col_pins = {{(A_W-COL_W){1'b0}}, lin_addr[COL_W-1:0]};
    end else begin : g_col_full
      assign col_pins = lin_addr[A_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);

  logic [CAS_LAT-1:0] lat_sr;

  generate
    if (CAS_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) lat_sr <= '0;
        else     lat_sr <= launch;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) lat_sr <= '0;
        else     lat_sr <= {lat_sr[CAS_LAT-2:0], launch};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= lat_sr[CAS_LAT-1];
      if (lat_sr[CAS_LAT-1]) rd_data <= dq_in;
    end
  end

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int A_W     = 12,
  parameter int DQ_W    = 16,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_WR    = 2,
  parameter int T_RP    = 2,
  localparam int MAXD   = max_of4(T_RCD, CAS_LAT, T_WR, T_RP),
  localparam int CNT_W  = $clog2(MAXD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [A_W-1:0]    req_row,
  input  logic [A_W-1:0]    req_col,
  output logic              ready,
  output sd_cmd_e           cmd_q,
  output logic              cs_n_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [A_W-1:0]    a_q,
  output logic              dqm_q,
  output logic              oe_q,
  output logic [DQ_W-1:0]   dq_out_q,
  output logic              rd_launch
);

  seq_state_e        state, state_n;
  logic [CNT_W-1:0]  cnt;
  logic              accept;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [A_W-1:0]    col_q;
  logic [DQ_W-1:0]   wdata_q;

  assign accept = (state == ST_IDLE) && ready && req_valid;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (accept)      state_n = ST_RCD;
      ST_RCD:  if (cnt == '0)   state_n = ST_POST;
      ST_POST: if (cnt == '0)   state_n = ST_RP;
      ST_RP:   if (cnt == '0)   state_n = ST_IDLE;
      default:                  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ready     <= 1'b0;
      cmd_q     <= CMD_NOP;
      cs_n_q    <= 1'b1;
      ba_q      <= '0;
      a_q       <= '0;
      dqm_q     <= 1'b1;
      oe_q      <= 1'b0;
      dq_out_q  <= '0;
      rd_launch <= 1'b0;
      wr_q      <= 1'b0;
      bank_q    <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
    end else begin
      state     <= state_n;
      ready     <= (state_n == ST_IDLE) && init_done;
      dqm_q     <= (state_n == ST_IDLE);
      cs_n_q    <= 1'b0;
      cmd_q     <= CMD_NOP;
      oe_q      <= 1'b0;
      rd_launch <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cmd_q   <= CMD_ACT;
            ba_q    <= req_bank;
            a_q     <= req_row;
            bank_q  <= req_bank;
            col_q   <= req_col;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            cnt     <= CNT_W'(T_RCD - 1);
          end
        end
        ST_RCD: begin
          if (cnt == '0) begin
            a_q  <= col_q;
            ba_q <= bank_q;
            if (wr_q) begin
              cmd_q    <= CMD_WR;
              oe_q     <= 1'b1;
              dq_out_q <= wdata_q;
              cnt      <= CNT_W'(T_WR - 1);
            end else begin
              cmd_q     <= CMD_RD;
              rd_launch <= 1'b1;
              cnt       <= CNT_W'(CAS_LAT - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_POST: begin
          if (cnt == '0) begin
            cmd_q <= CMD_PRE;
            a_q   <= '0;
            ba_q  <= bank_q;
            cnt   <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Cycles elapsed since the last ACTIVE, used only by the checks below.
  logic [7:0] act_age;
  always_ff @(posedge clk) begin
    if (rst)                   act_age <= 8'hFF;
    else if (cmd_q == CMD_ACT) act_age <= 8'd1;
    else if (act_age != 8'hFF) act_age <= act_age + 8'd1;
  end

  // R3
  rw_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> act_age == 8'(T_RCD));

  // R4
  pre_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (!a_q[10] && ba_q == bank_q));

  // R7
  oe_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> cmd_q == CMD_WR);

  // R5
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> cmd_q == CMD_NOP);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int WIDE_COL = 0,
  parameter int DQ_W     = 16,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 12,
  parameter int A_W      = 12,
  parameter int T_RCD    = 2,
  parameter int CAS_LAT  = 2,
  parameter int T_WR     = 2,
  parameter int T_RP     = 2,
  localparam int COL_W   = (WIDE_COL != 0) ? 10 : 9,
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [A_W-1:0]    sd_a,
  output logic              sd_dqm,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);

  logic [BANK_W-1:0] f_bank;
  logic [A_W-1:0]    f_row;
  logic [A_W-1:0]    f_col;
  sd_cmd_e           cmd;
  logic              launch;

  sdram_addr_split #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)
  ) u_split (
    .lin_addr(req_addr),
    .bank    (f_bank),
    .row_pins(f_row),
    .col_pins(f_col)
  );

  sdram_cmd_fsm #(
    .BANK_W(BANK_W), .A_W(A_W), .DQ_W(DQ_W),
    .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_WR(T_WR), .T_RP(T_RP)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .init_done(init_done),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_wdata(req_wdata),
    .req_bank (f_bank),
    .req_row  (f_row),
    .req_col  (f_col),
    .ready    (ready),
    .cmd_q    (cmd),
    .cs_n_q   (sd_cs_n),
    .ba_q     (sd_ba),
    .a_q      (sd_a),
    .dqm_q    (sd_dqm),
    .oe_q     (sd_dq_oe),
    .dq_out_q (sd_dq_out),
    .rd_launch(launch)
  );

  sdram_rd_capture #(
    .CAS_LAT(CAS_LAT), .DQ_W(DQ_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .dq_in   (sd_dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // R1
  idle_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && sd_dqm) |-> ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111));

  // R6
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD) |-> !sd_dq_oe);

endmodule

// File: tb/sdram_seq_tb.sv
module sdram_seq_tb;

  localparam int DQ_W = 16, BANK_W = 2, ROW_W = 12, COL_W = 9, A_W = 12;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int T_RCD = 2, CAS_LAT = 2, T_WR = 2, T_RP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_done = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [DQ_W-1:0] rd_data, sd_dq_out;
  logic [DQ_W-1:0] sd_dq_in = 16'h0BAD;
  logic [BANK_W-1:0] sd_ba;
  logic [A_W-1:0] sd_a;

  always #10 clk = ~clk;

  sdram_seq u_dut (
    .clk(clk), .rst(rst), .init_done(init_done), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  typedef struct {
    bit wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [DQ_W-1:0] data;
  } item_t;

  item_t cmd_q[$];
  logic [DQ_W-1:0] rd_q[$];
  logic [DQ_W-1:0] shadow [int];
  logic [DQ_W-1:0] dev_mem [int];

  function automatic logic [DQ_W-1:0] fill(input int key);
    return DQ_W'(key) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: waits for ready, presents one request, records expectations.
  task automatic do_req(input bit wr, input logic [ADDR_W-1:0] addr, input logic [DQ_W-1:0] d);
    item_t it;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d;
    it.wr = wr;
    it.bank = addr[ADDR_W-1 -: BANK_W];
    it.row  = addr[COL_W +: ROW_W];
    it.col  = addr[COL_W-1:0];
    it.data = d;
    cmd_q.push_back(it);
    if (wr) shadow[int'(addr)] = d;
    else rd_q.push_back(shadow.exists(int'(addr)) ? shadow[int'(addr)] : fill(int'(addr)));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Memory model: returns read data so it is sampled CAS_LAT+1 edges after the READ cycle starts.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !sd_cs_n && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b101 && cmd_q.size() > 0) begin
        int key;
        logic [DQ_W-1:0] d;
        key = int'({cmd_q[0].bank, cmd_q[0].row, sd_a[COL_W-1:0]});
        d = dev_mem.exists(key) ? dev_mem[key] : fill(key);
        @(posedge clk);
        repeat (CAS_LAT - 1) @(posedge clk);
        #1 sd_dq_in = d;
        @(posedge clk);
        #1 sd_dq_in = 16'h0BAD;
      end
    end
  end

  // Protocol and scoreboard monitor.
  int act_cyc = 0, rw_cyc = 0, pre_cyc = 0, rdcmd_cyc = 0;
  bit pend_pre = 0, prev_ready = 0, prev_rdv = 0, last_wr = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        logic [2:0] c;
        c = {sd_ras_n, sd_cas_n, sd_we_n};
        if (sd_dq_oe && c != 3'b100) chk(0, "R7 oe outside WRITE", 32'(c), 32'h4);
        if (c == 3'b011) begin
          if (cmd_q.size() == 0) chk(0, "R2 unexpected ACTIVE", 0, 1);
          else begin
            chk(sd_ba == cmd_q[0].bank, "R2 ACTIVE bank", 32'(sd_ba), 32'(cmd_q[0].bank));
            chk(sd_a == A_W'(cmd_q[0].row), "R2 ACTIVE row", 32'(sd_a), 32'(cmd_q[0].row));
          end
          chk(!ready, "R5 ready low after accept", 32'(ready), 0);
          chk(!sd_dqm, "R8 dqm low from ACTIVE", 32'(sd_dqm), 0);
          act_cyc = cyc;
        end else if ((c == 3'b101 || c == 3'b100) && cmd_q.size() > 0) begin
          chk(cyc - act_cyc == T_RCD, "R3 ACTIVE to column spacing", 32'(cyc - act_cyc), 32'(T_RCD));
          chk(sd_a == A_W'(cmd_q[0].col), "R3 column pins", 32'(sd_a), 32'(cmd_q[0].col));
          chk(sd_ba == cmd_q[0].bank, "R3 column bank", 32'(sd_ba), 32'(cmd_q[0].bank));
          chk((c == 3'b100) == cmd_q[0].wr, "R3 direction", 32'(c), 32'(cmd_q[0].wr ? 4 : 5));
          if (c == 3'b100) begin
            chk(sd_dq_oe && sd_dq_out == cmd_q[0].data, "R7 write data", 32'(sd_dq_out), 32'(cmd_q[0].data));
            chk(!sd_dqm, "R8 dqm on WRITE", 32'(sd_dqm), 0);
            if (sd_dq_oe && !sd_dqm)
              dev_mem[int'({cmd_q[0].bank, cmd_q[0].row, sd_a[COL_W-1:0]})] = sd_dq_out;
          end else begin
            chk(!sd_dq_oe, "R6 bus released on READ", 32'(sd_dq_oe), 0);
            rdcmd_cyc = cyc;
          end
          last_wr = (c == 3'b100);
          rw_cyc = cyc;
        end else if (c == 3'b010 && cmd_q.size() > 0) begin
          chk(cyc - rw_cyc == (last_wr ? T_WR : CAS_LAT), "R4 precharge spacing",
              32'(cyc - rw_cyc), 32'(last_wr ? T_WR : CAS_LAT));
          chk(sd_ba == cmd_q[0].bank && !sd_a[10], "R4 precharge bank and A10",
              32'({sd_a[10], sd_ba}), 32'(cmd_q[0].bank));
          void'(cmd_q.pop_front());
          pre_cyc = cyc;
          pend_pre = 1;
        end
        if (ready && !prev_ready && pend_pre) begin
          chk(cyc - pre_cyc == T_RP, "R5 ready after precharge", 32'(cyc - pre_cyc), 32'(T_RP));
          chk(sd_dqm, "R8 dqm high when idle", 32'(sd_dqm), 1);
          pend_pre = 0;
        end
        if (rd_valid) begin
          chk(!prev_rdv, "R6 single-cycle strobe", 32'(prev_rdv), 0);
          chk(cyc - rdcmd_cyc == CAS_LAT + 1, "R6 read latency", 32'(cyc - rdcmd_cyc), 32'(CAS_LAT + 1));
          if (rd_q.size() == 0) chk(0, "R6 unexpected rd_valid", 1, 0);
          else begin
            logic [DQ_W-1:0] e;
            e = rd_q.pop_front();
            chk(rd_data == e, "R6 read data", 32'(rd_data), 32'(e));
          end
        end
        prev_ready = ready;
        prev_rdv = rd_valid;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 32'(cyc), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R8: reset state
    chk(!ready, "R1 ready in reset", 32'(ready), 0);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 NOP in reset", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk(!rd_valid && !sd_dq_oe, "R6 R7 quiet in reset", 32'({rd_valid, sd_dq_oe}), 0);
    chk(sd_dqm, "R8 dqm in reset", 32'(sd_dqm), 1);
    rst = 1'b0;
    // R1: a request before initialization must be ignored
    req_valid = 1'b1; req_write = 1'b1; req_addr = 23'h12345; req_wdata = 16'hDEAD;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!ready, "R1 ready low before init", 32'(ready), 0);
      chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 no command before init",
          32'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    end
    req_valid = 1'b0;
    init_done = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(ready, "R1 ready after init", 32'(ready), 1);
    // R1: the ignored write must not have reached memory
    do_req(0, 23'h12345, '0);
    // main traffic
    do_req(1, 23'h000000, 16'h1111);
    do_req(0, 23'h000000, '0);
    do_req(1, 23'h7FFFFF, 16'hBEEF);
    do_req(0, 23'h7FFFFF, '0);
    do_req(1, {2'd1, 12'hABC, 9'h1FF}, 16'hA001);
    do_req(1, {2'd2, 12'hABC, 9'h1FF}, 16'hA002);
    do_req(1, {2'd3, 12'hABC, 9'h000}, 16'hA003);
    do_req(0, {2'd2, 12'hABC, 9'h1FF}, '0);
    do_req(0, {2'd1, 12'hABC, 9'h1FF}, '0);
    do_req(0, {2'd3, 12'hABC, 9'h000}, '0);
    do_req(0, {2'd0, 12'h800, 9'h100}, '0);
    do_req(1, {2'd0, 12'h800, 9'h100}, 16'h0F0F);
    do_req(0, {2'd0, 12'h800, 9'h100}, '0);
    @(negedge clk);
    while (!ready || rd_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cmd_q.size() == 0 && rd_q.size() == 0, "R6 scoreboard drained",
        32'(cmd_q.size() + rd_q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule